// File: doc/BRIEF.md
# Ethernet Receive Frame Packer

This block sits behind a MAC receiver. It takes a byte stream with start and end markers, and that stream includes the four trailing checksum bytes. It packs each frame into 32-bit words in an internal word store. A host then pulls the words out one at a time through a read strobe. Each stored frame begins with a word that carries a 16-bit length together with the first two frame bytes.

The block keeps a hardware count of complete frames waiting to be read. It also holds two sticky event flags: one for a stored frame and one for lost data. A flush control empties the store. Frames are admitted only while the receive enable is high.

A frame is kept only when the whole of it fits. If space runs out partway, the frame is abandoned and its words are reclaimed, so frames already stored stay readable.

Top module: `rx_frame_packer`

## Requirements
- R1: The first word of a frame of N stream bytes (checksum included) holds N+2 in bits 15:0, stream byte 0 in bits 23:16 and stream byte 1 in bits 31:24. For a one-byte frame, bits 31:24 are zero.
- R2: Each later word k (k ≥ 1) holds stream bytes 4k-2 up to 4k+1, lowest byte in bits 7:0. A frame occupies (N+2+3)/4 words in total, and the checksum bytes are the last bytes stored.
- R3: The byte lanes of a frame's final word that lie beyond byte N-1 read as zero.
- R4: `pkt_count` is 0 after reset. It rises by one for each frame stored and falls by one when the host reads a frame's final word. Outside a flush it moves by at most one per cycle.
- R5: `rx_irq` sets when a frame becomes readable and stays set until `rx_ack` is pulsed. A set and an acknowledge in the same cycle leave it set.
- R6: A frame that does not fit in the free space is dropped whole and sets `ovr_irq`, which stays set until `ovr_ack`. Frames stored earlier read back unchanged. A frame that exactly fills the store is kept.
- R7: A `fifo_flush` pulse empties the store, zeroes `pkt_count` and discards any frame being received. Bytes of that frame that arrive without a new start marker are ignored.
- R8: A frame whose start marker arrives while `rx_en` is low is ignored entirely.
- R9: A read strobe while `pkt_count` is 0 returns zero on `rd_data` and changes no state.
- R10: A frame whose end byte is sampled at clock edge k appears in `pkt_count` after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Admits new frames while high |
| fifo_flush | input | 1 | Empties the store and the frame count |
| in_valid | input | 1 | Stream byte present |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame (last checksum byte) |
| in_byte | input | 8 | Stream byte |
| rd_req | input | 1 | Host read strobe, one word per cycle |
| rd_data | output | 32 | Word at the read position, zero when nothing is waiting |
| pkt_count | output | CNT_W | Complete frames waiting |
| rx_ack | input | 1 | Clears `rx_irq` |
| ovr_ack | input | 1 | Clears `ovr_irq` |
| rx_irq | output | 1 | Sticky: a frame was stored |
| ovr_irq | output | 1 | Sticky: a frame was lost for lack of space |

## Verification
The assertions take it for granted that the stream carries at most one byte per cycle and sets `in_eop` exactly once per frame. They also assume no frame exceeds 65532 bytes and that the host strobes reads only for words it knows are there. The stimulus keeps to these rules: every frame starts with `in_sop`, and the only tail arriving without a start marker is the deliberately orphaned one after a flush. Read strobes cover exactly the word count computed from each frame's length, except for the single read on an empty store.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   localparam int LEN_W  = 16;
   localparam int WORD_W = 32;
   // length field counts stream bytes plus the two bytes of the field itself
   localparam int LEN_ADJ = 2;

   function automatic logic [LEN_W-1:0] words_for_len(input logic [LEN_W-1:0] len);
      logic [LEN_W:0] t;
      t = ({1'b0, len} + (LEN_W+1)'(3)) >> 2;
      return t[LEN_W-1:0];
   endfunction
endpackage

// File: rtl/rxp_wordbuf.sv
module rxp_wordbuf #(
   parameter int DEPTH     = 64,
   parameter int AW        = $clog2(DEPTH),
   parameter bit CLEAR_MEM = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [31:0]   rd_word
);
   logic [31:0] mem [DEPTH];

   generate
      if (CLEAR_MEM) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/rxp_writer.sv
module rxp_writer
   import rxp_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          rx_en,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic [7:0]    in_byte,
   input  logic [PW-1:0] free_words,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [31:0]   wr_data,
   output logic [PW-1:0] commit_ptr,
   output logic          frame_stored,
   output logic          overrun
);
   localparam int FW = PW + 1;

   logic             in_frame_q, drop_q;
   logic [LEN_W-1:0] cnt_q;
   logic [7:0]       b0_q, b1_q;
   logic [2:0][7:0]  acc_q;
   logic [PW-1:0]    wptr_q, hdr_q, commit_q;
   logic [FW-1:0]    words_q;
   logic             hp_v_q;
   logic [AW-1:0]    hp_a_q;
   logic [31:0]      hp_d_q;

   logic             take, start, is_data, need_wr, fits, start_full;
   logic             base_drop, new_drop, do_wr, ovr_now, commit_now;
   logic [LEN_W-1:0] idx, len_c;
   logic [1:0]       lane;
   logic [FW-1:0]    base_words;
   logic [PW-1:0]    base_wptr, wptr_n, hdr_n;
   logic [7:0]       b0_n, b1_n;
   logic [31:0]      asm_word;

   assign take       = in_valid && (in_sop ? rx_en : in_frame_q);
   assign start      = take && in_sop;
   assign idx        = in_sop ? '0 : cnt_q;
   assign is_data    = idx >= LEN_W'(2);
   assign lane       = idx[1:0] + 2'd2;
   assign start_full = start && (free_words == '0);
   assign base_drop  = start ? start_full : drop_q;
   assign base_words = start ? FW'(1) : words_q;
   assign base_wptr  = start ? commit_q + PW'(1) : wptr_q;
   assign hdr_n      = start ? commit_q : hdr_q;

   generate
      for (genvar l = 0; l < 4; l++) begin : g_lane
         if (l < 3) begin : g_held
            assign asm_word[8*l +: 8] = (lane == 2'(l)) ? in_byte :
                                        ((2'(l) < lane) ? acc_q[l] : 8'h00);
         end else begin : g_top
            assign asm_word[31:24] = (lane == 2'd3) ? in_byte : 8'h00;
         end
      end
   endgenerate

   assign need_wr    = take && is_data && ((lane == 2'd3) || in_eop);
   assign fits       = (base_words + FW'(1)) <= FW'(free_words);
   assign do_wr      = need_wr && !base_drop && fits;
   assign new_drop   = base_drop || (need_wr && !fits);
   assign ovr_now    = start_full || (need_wr && !base_drop && !fits);
   assign commit_now = take && in_eop && !new_drop;
   assign wptr_n     = base_wptr + {{(PW-1){1'b0}}, do_wr};
   assign len_c      = idx + LEN_W'(LEN_ADJ + 1);
   assign b0_n       = (take && idx == '0) ? in_byte : b0_q;
   assign b1_n       = (take && idx == '0) ? 8'h00 :
                       ((take && idx == LEN_W'(1)) ? in_byte : b1_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;  drop_q <= 1'b0;  cnt_q <= '0;
         b0_q <= '0;  b1_q <= '0;  acc_q <= '0;
         wptr_q <= '0;  hdr_q <= '0;  commit_q <= '0;  words_q <= '0;
         hp_v_q <= 1'b0;  hp_a_q <= '0;  hp_d_q <= '0;
      end else if (flush) begin
         in_frame_q <= 1'b0;  drop_q <= 1'b0;  cnt_q <= '0;
         wptr_q <= '0;  hdr_q <= '0;  commit_q <= '0;  words_q <= '0;
         hp_v_q <= 1'b0;
      end else begin
         hp_v_q <= commit_now;
         if (commit_now) begin
            hp_a_q   <= hdr_n[AW-1:0];
            hp_d_q   <= {b1_n, b0_n, len_c};
            commit_q <= wptr_n;
         end
         if (take) begin
            in_frame_q <= !in_eop;
            cnt_q      <= idx + LEN_W'(1);
            drop_q     <= new_drop;
            words_q    <= base_words + {{(FW-1){1'b0}}, do_wr};
            wptr_q     <= wptr_n;
            hdr_q      <= hdr_n;
            b0_q       <= b0_n;
            b1_q       <= b1_n;
            if (is_data && lane != 2'd3) acc_q[lane] <= in_byte;
         end
      end
   end

   assign wr_en        = hp_v_q || do_wr;
   assign wr_addr      = hp_v_q ? hp_a_q : base_wptr[AW-1:0];
   assign wr_data      = hp_v_q ? hp_d_q : asm_word;
   assign commit_ptr   = commit_q;
   assign frame_stored = hp_v_q;
   assign overrun      = ovr_now;
endmodule

// File: rtl/rxp_reader.sv
module rxp_reader
   import rxp_pkg::*;
#(
   parameter int AW    = 6,
   parameter int PW    = AW + 1,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             rd_req,
   input  logic             frame_stored,
   input  logic [31:0]      mem_word,
   output logic [PW-1:0]    rd_ptr,
   output logic [CNT_W-1:0] pkt_count,
   output logic [31:0]      rd_data
);
   logic [PW-1:0]    ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W-1:0] left_q, left_n;
   logic             avail, fire, last;

   assign avail  = cnt_q != '0;
   assign fire   = rd_req && avail;
   assign left_n = (left_q == '0) ? words_for_len(mem_word[LEN_W-1:0]) - LEN_W'(1)
                                  : left_q - LEN_W'(1);
   assign last   = left_n == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;  cnt_q <= '0;  left_q <= '0;
      end else if (flush) begin
         ptr_q <= '0;  cnt_q <= '0;  left_q <= '0;
      end else begin
         if (fire) begin
            ptr_q  <= ptr_q + PW'(1);
            left_q <= left_n;
         end
         case ({frame_stored, fire && last})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_ptr    = ptr_q;
   assign pkt_count = cnt_q;
   assign rd_data   = avail ? mem_word : 32'h0;
endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer #(
   parameter int DEPTH     = 64,
   parameter int CNT_W     = 7,
   parameter bit CLEAR_MEM = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             fifo_flush,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [7:0]       in_byte,
   input  logic             rd_req,
   output logic [31:0]      rd_data,
   output logic [CNT_W-1:0] pkt_count,
   input  logic             rx_ack,
   input  logic             ovr_ack,
   output logic             rx_irq,
   output logic             ovr_irq
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
      $error("CNT_W too narrow for the frames DEPTH words can hold");
   end

   logic          wr_en, stored, ovr_pulse;
   logic [AW-1:0] wr_addr;
   logic [31:0]   wr_data, mem_word;
   logic [PW-1:0] commit_ptr, rd_ptr, used, free_words;
   logic          rx_q, ovr_q;

   assign used       = commit_ptr - rd_ptr;
   assign free_words = PW'(DEPTH) - used;

   rxp_writer #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_writer (
      .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .rx_en(rx_en),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
      .free_words(free_words), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_ptr(commit_ptr), .frame_stored(stored), .overrun(ovr_pulse)
   );

   rxp_wordbuf #(.DEPTH(DEPTH), .AW(AW), .CLEAR_MEM(CLEAR_MEM)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_ptr[AW-1:0]), .rd_word(mem_word)
   );

   rxp_reader #(.AW(AW), .PW(PW), .CNT_W(CNT_W)) u_reader (
      .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .rd_req(rd_req),
      .frame_stored(stored), .mem_word(mem_word), .rd_ptr(rd_ptr),
      .pkt_count(pkt_count), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         rx_q  <= stored    || (rx_q  && !rx_ack);
         ovr_q <= ovr_pulse || (ovr_q && !ovr_ack);
      end
   end

   assign rx_irq  = rx_q;
   assign ovr_irq = ovr_q;
endmodule

// File: rtl/rx_frame_packer_chk.sv
module rx_frame_packer_chk #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_flush,
   input logic             in_valid,
   input logic             rd_req,
   input logic [31:0]      rd_data,
   input logic [CNT_W-1:0] pkt_count,
   input logic             rx_ack,
   input logic             ovr_ack,
   input logic             rx_irq,
   input logic             ovr_irq
);
   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_flush |=> (pkt_count == $past(pkt_count) ||
                       pkt_count == $past(pkt_count) + CNT_W'(1) ||
                       pkt_count == $past(pkt_count) - CNT_W'(1)));
   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |=> (pkt_count == '0 && rd_data == 32'h0));
   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && pkt_count == '0) |-> rd_data == 32'h0);
   // R5
   rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> pkt_count != '0);
   // R5
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !rx_ack) |=> rx_irq);
   // R6
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_irq && !ovr_ack) |=> ovr_irq);
   // R6
   ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_irq) |-> $past(in_valid));
endmodule

bind rx_frame_packer rx_frame_packer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_frame_packer_bench.sv
`timescale 1ns/1ps
module rx_frame_packer_bench;
   localparam int DEPTH = 16;
   localparam int CNT_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_en = 1'b1, fifo_flush = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0] in_byte = 8'h0;
   logic rd_req = 1'b0, rx_ack = 1'b0, ovr_ack = 1'b0;
   logic [31:0] rd_data;
   logic [CNT_W-1:0] pkt_count;
   logic rx_irq, ovr_irq;

   int total = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rx_frame_packer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_frame_packer (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_flush(fifo_flush),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
      .rd_req(rd_req), .rd_data(rd_data), .pkt_count(pkt_count),
      .rx_ack(rx_ack), .ovr_ack(ovr_ack), .rx_irq(rx_irq), .ovr_irq(ovr_irq)
   );

   function automatic logic [7:0] bval(input int n, input int i);
      return 8'((n * 29 + i * 11 + 5) & 255);
   endfunction

   function automatic logic [31:0] exp_word(input int n, input int k);
      logic [31:0] w;
      if (k == 0) begin
         w = {(n > 1) ? bval(n, 1) : 8'h00, bval(n, 0), 16'(n + 2)};
      end else begin
         for (int j = 0; j < 4; j++) begin
            int ix = 2 + 4 * (k - 1) + j;
            w[8*j +: 8] = (ix < n) ? bval(n, ix) : 8'h00;
         end
      end
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input int n, input bit idle_after);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1);
         in_byte = bval(n, i);
      end
      if (idle_after) begin
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
   endtask

   task automatic read_frame(input int n);
      int nw = (n + 5) / 4;
      for (int k = 0; k < nw; k++) begin
         @(negedge clk);
         if (k == 0)
            chk(rd_data == exp_word(n, 0), "R1 header word", rd_data, exp_word(n, 0));
         else if (k == nw - 1)
            chk(rd_data == exp_word(n, k), "R3 final word lanes", rd_data, exp_word(n, k));
         else
            chk(rd_data == exp_word(n, k), "R2 body word", rd_data, exp_word(n, k));
         rd_req = 1'b1;
      end
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pkt_count == 0, "R4 reset count", 32'(pkt_count), 0);
      chk(!rx_irq && !ovr_irq, "R5 reset flags", {30'b0, rx_irq, ovr_irq}, 0);

      // R9: read on an empty store
      rd_req = 1'b1;
      chk(rd_data == 0, "R9 empty read data", rd_data, 0);
      @(negedge clk);
      rd_req = 1'b0;
      chk(pkt_count == 0, "R9 empty read count", 32'(pkt_count), 0);

      // R10: count appears one edge after the end byte's edge
      send(6, 1'b1);
      chk(pkt_count == 0, "R10 not yet counted", 32'(pkt_count), 0);
      @(negedge clk);
      chk(pkt_count == 1, "R10 counted", 32'(pkt_count), 1);
      chk(rx_irq, "R5 rx flag set", 32'(rx_irq), 1);
      read_frame(6);   // R9: the empty read moved no pointer
      chk(rx_irq, "R5 rx flag sticky", 32'(rx_irq), 1);
      rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
      chk(!rx_irq, "R5 rx flag acked", 32'(rx_irq), 0);

      // sweep of frame sizes
      for (int n = 1; n <= 30; n++) begin
         send(n, 1'b1);
         @(negedge clk);
         chk(pkt_count == 1, "R4 one frame waiting", 32'(pkt_count), 1);
         read_frame(n);
         chk(pkt_count == 0, "R4 frame consumed", 32'(pkt_count), 0);
      end

      // back-to-back frames
      send(3, 1'b0); send(5, 1'b0); send(8, 1'b1);
      @(negedge clk);
      chk(pkt_count == 3, "R4 three frames", 32'(pkt_count), 3);
      read_frame(3); read_frame(5); read_frame(8);
      chk(pkt_count == 0, "R4 all consumed", 32'(pkt_count), 0);

      // R6: third frame does not fit
      send(20, 1'b1); send(20, 1'b1); send(20, 1'b1);
      @(negedge clk);
      chk(pkt_count == 2, "R6 third dropped", 32'(pkt_count), 2);
      chk(ovr_irq, "R6 overrun set", 32'(ovr_irq), 1);
      read_frame(20); read_frame(20);
      chk(pkt_count == 0, "R6 stored frames intact", 32'(pkt_count), 0);
      ovr_ack = 1'b1; @(negedge clk); ovr_ack = 1'b0;
      chk(!ovr_irq, "R6 overrun acked", 32'(ovr_irq), 0);

      // R6: exact fill kept, one more byte dropped
      send(62, 1'b1);
      @(negedge clk);
      chk(pkt_count == 1 && !ovr_irq, "R6 exact fill kept",
          {pkt_count, 26'b0, ovr_irq}, {5'd1, 27'b0});
      read_frame(62);
      send(63, 1'b1);
      @(negedge clk);
      chk(pkt_count == 0, "R6 oversize dropped", 32'(pkt_count), 0);
      chk(ovr_irq, "R6 oversize overrun", 32'(ovr_irq), 1);
      ovr_ack = 1'b1; @(negedge clk); ovr_ack = 1'b0;
      send(10, 1'b1);
      @(negedge clk);
      read_frame(10);
      chk(pkt_count == 0, "R6 space reclaimed", 32'(pkt_count), 0);

      // R8: disabled receive
      rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
      rx_en = 1'b0;
      send(8, 1'b1);
      @(negedge clk);
      chk(pkt_count == 0 && !rx_irq, "R8 frame ignored",
          {pkt_count, 26'b0, rx_irq}, 0);
      rx_en = 1'b1;

      // R7: flush mid-frame
      send(9, 1'b1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = (i == 0); in_eop = 1'b0; in_byte = bval(12, i);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; fifo_flush = 1'b1;
      @(negedge clk);
      fifo_flush = 1'b0;
      chk(pkt_count == 0, "R7 flush count", 32'(pkt_count), 0);
      chk(rd_data == 0, "R7 flush data", rd_data, 0);
      for (int i = 5; i < 12; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 11); in_byte = bval(12, i);
      end
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
      @(negedge clk);
      chk(pkt_count == 0, "R7 orphan tail ignored", 32'(pkt_count), 0);
      send(7, 1'b1);
      @(negedge clk);
      chk(pkt_count == 1, "R7 after flush", 32'(pkt_count), 1);
      read_frame(7);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule